// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a register-programmed SPI master that runs one flash command each time software triggers it. Software writes an opcode into its own register and the transmit and receive byte counts into one packed register. It then rewinds a shared eight-entry byte FIFO, fills it with the outgoing bytes through a single data port, and sets the start bit. The opcode never passes through the FIFO.

While the command runs, chip select stays low. The engine shifts the opcode out first, then the FIFO bytes, then clocks in the response bytes. Every byte sampled from MISO after the opcode is written back into the FIFO at the running pointer. Software then rewinds the FIFO, skips the entries from the transmit phase and reads the response. The FIFO pointer is visible to software, so a driver can check that nothing else moved it.

Top module: `spi_cmd_engine`

## Requirements
- R1: Offset 0x0 holds the opcode. Each command starts by shifting this opcode out MSB first. The opcode is never read from the FIFO.
- R2: Offset 0x1 holds the counts: receive count in bits 7:4 and transmit count, opcode excluded, in bits 3:0. The value read back after a command equals the value written before it.
- R3: Writing offset 0x2 with bit 4 set moves the FIFO pointer to 0. Writing bit 0 set starts a command. A single write with both bits set rewinds the pointer first and then runs the command from entry 0.
- R4: While a command runs, busy_o is 1 and bit 0 of offset 0x2 reads 1. Both return to 0 in the same cycle that chip select goes high.
- R5: Offset 0xC is the FIFO data port. Each bus write stores a byte at the pointer and each bus read returns the entry at the pointer, and then the pointer advances. Bits 2:0 of offset 0xD show the 3-bit pointer, which wraps modulo 8.
- R6: After a command with counts tx and rx, the FIFO holds the tx bytes sampled during the transmit phase, followed by the rx response bytes, stored from the starting pointer onward. The pointer ends at (tx+rx) mod 8.
- R7: During the transmit phase, MOSI carries the FIFO entries in pointer order. During the receive phase, MOSI carries 0x00.
- R8: Chip select is low for exactly the cycles busy_o is high, covering the opcode, transmit and receive bytes. The bus follows SPI mode 0: SCK idles low, MOSI changes only while SCK is low, and MISO is sampled while SCK is high.
- R9: Bits 5:4 of offset 0xD set the bit time. A value of 1 gives 2 core cycles per bit, 2 gives 3, 3 gives 4, and the reserved value 0 gives 4. A command lasts exactly (1+tx+rx)*8*bit-time cycles. The field resets to 3.
- R10: While busy, the block ignores all register writes, FIFO port accesses and start or rewind requests: none of them changes the opcode, counts, speed, pointer or FIFO contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 4 | Register byte offset |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register |
| busy_o | output | 1 | Command in progress |
| spi_sck_o | output | 1 | SPI clock |
| spi_mosi_o | output | 1 | Serial data out |
| spi_miso_i | input | 1 | Serial data in |
| spi_cs_no | output | 1 | Chip select, active low |

## Verification
The bench targets the following corner cases:

- **Wrap and overwrite.** A command whose transmit and receive bytes together pass the eight-entry boundary must overwrite the oldest entries in order. A design with a wrong pointer step leaves stale bytes there and reports a final pointer other than (tx+rx) mod 8.
- **Full FIFO and opcode-only.** With eight transmit bytes, the load leaves the pointer back at 0. A command with both counts zero shifts only the opcode. A sequencer that counts the opcode as a FIFO byte, or that fetches the next byte from the wrong entry, shows wrong MOSI bytes or a wrong command length.
- **Reserved speed and combined write.** The reserved speed code must still run at the slowest rate. A single control write that both rewinds and starts must run from entry 0.
- **Writes while busy.** Register and FIFO writes made during a command must be dropped. If they are accepted, the readback shows corrupted counts, opcode or pointer, or a second command is started.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int REG_AW = 4;

  localparam logic [REG_AW-1:0] A_OPC = 4'h0;
  localparam logic [REG_AW-1:0] A_CNT = 4'h1;
  localparam logic [REG_AW-1:0] A_CTL = 4'h2;
  localparam logic [REG_AW-1:0] A_DAT = 4'hC;
  localparam logic [REG_AW-1:0] A_STA = 4'hD;

  localparam int CTL_GO  = 0;
  localparam int CTL_RWD = 4;
  localparam int STA_SPD = 4;

  localparam logic [1:0] SPD_RST = 2'd3;

  // core cycles per SPI bit for each speed code
  function automatic logic [2:0] bit_div(input logic [1:0] spd);
    case (spd)
      2'd1:    return 3'd2;
      2'd2:    return 3'd3;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/spi_cmd_fifo.sv
module spi_cmd_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rewind_i,
  input  logic          adv_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] cur_o,
  output logic [DW-1:0] next_o,
  output logic [PW-1:0] ptr_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] ptr_q;
  logic [PW-1:0] ptr_nx;

  assign ptr_nx = ptr_q + 1'b1;
  assign cur_o  = mem_q[ptr_q];
  assign next_o = mem_q[ptr_nx];
  assign ptr_o  = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (wr_en_i) mem_q[ptr_q] <= wr_data_i;
      if (rewind_i)   ptr_q <= '0;
      else if (adv_i) ptr_q <= ptr_nx;
    end
  end

  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !rewind_i |=> ptr_o == $past(ptr_o) + 1'b1); // R5
  AST_PTR_REWIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rewind_i |=> ptr_o == '0); // R3
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs import spi_cmd_pkg::*; #(
  parameter int DW = 8,
  parameter int CW = 4,
  parameter int PW = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              busy_i,
  input  logic [PW-1:0]     ptr_i,
  input  logic [DW-1:0]     fifo_cur_i,
  output logic [DW-1:0]     opcode_o,
  output logic [CW-1:0]     tx_cnt_o,
  output logic [CW-1:0]     rx_cnt_o,
  output logic [1:0]        speed_o,
  output logic              start_o,
  output logic              rewind_o,
  output logic              fifo_wr_o,
  output logic              fifo_adv_o
);
  logic [DW-1:0]   opc_q;
  logic [2*CW-1:0] cnt_q;
  logic [1:0]      spd_q;
  logic            wr_ok;

  assign wr_ok = wr_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opc_q <= '0;
      cnt_q <= '0;
      spd_q <= SPD_RST;
    end else if (wr_ok) begin
      case (addr_i)
        A_OPC:   opc_q <= wdata_i;
        A_CNT:   cnt_q <= wdata_i[2*CW-1:0];
        A_STA:   spd_q <= wdata_i[STA_SPD+1:STA_SPD];
        default: ;
      endcase
    end
  end

  assign opcode_o   = opc_q;
  assign tx_cnt_o   = cnt_q[CW-1:0];
  assign rx_cnt_o   = cnt_q[2*CW-1:CW];
  assign speed_o    = spd_q;
  assign start_o    = wr_ok && addr_i == A_CTL && wdata_i[CTL_GO];
  assign rewind_o   = wr_ok && addr_i == A_CTL && wdata_i[CTL_RWD];
  assign fifo_wr_o  = wr_ok && addr_i == A_DAT;
  assign fifo_adv_o = (wr_i || rd_i) && !busy_i && addr_i == A_DAT;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_OPC: rdata_o = opc_q;
      A_CNT: rdata_o[2*CW-1:0] = cnt_q;
      A_CTL: rdata_o[CTL_GO] = busy_i;
      A_DAT: rdata_o = fifo_cur_i;
      A_STA: begin
        rdata_o[PW-1:0] = ptr_i;
        rdata_o[STA_SPD+1:STA_SPD] = spd_q;
      end
      default: rdata_o = '0;
    endcase
  end

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && $past(busy_i) |-> $stable(cnt_q)); // R2
  AST_OPC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && $past(busy_i) |-> $stable(opc_q) && $stable(spd_q)); // R10
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq import spi_cmd_pkg::*; #(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] opcode_i,
  input  logic [CW-1:0] tx_cnt_i,
  input  logic [CW-1:0] rx_cnt_i,
  input  logic [1:0]    speed_i,
  input  logic [DW-1:0] fifo_cur_i,
  input  logic [DW-1:0] fifo_next_i,
  output logic          fifo_wr_o,
  output logic [DW-1:0] fifo_wdata_o,
  output logic          busy_o,
  output logic          sck_o,
  output logic          mosi_o,
  input  logic          miso_i,
  output logic          cs_no
);
  localparam int BITW = $clog2(DW);
  localparam int BYW  = CW + 2;

  logic            run_q;
  logic [2:0]      ph_q, div_q;
  logic [BITW-1:0] bit_q;
  logic [BYW-1:0]  byte_q;
  logic [DW-1:0]   tx_sh_q, rx_sh_q;
  logic [DW-1:0]   captured, next_tx;
  logic [BYW-1:0]  total;
  logic            last_ph, last_bit, last_byte;

  assign total     = BYW'(tx_cnt_i) + BYW'(rx_cnt_i);
  assign last_ph   = ph_q == div_q - 3'd1;
  assign last_bit  = bit_q == BITW'(DW - 1);
  assign last_byte = byte_q == total;
  assign captured  = {rx_sh_q[DW-2:0], miso_i};
  // after the opcode the pointer has not moved; later bytes just wrote ptr
  assign next_tx   = (byte_q == '0) ? fifo_cur_i : fifo_next_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      ph_q    <= '0;
      div_q   <= 3'd4;
      bit_q   <= '0;
      byte_q  <= '0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
    end else if (!run_q) begin
      if (start_i) begin
        run_q   <= 1'b1;
        ph_q    <= '0;
        bit_q   <= '0;
        byte_q  <= '0;
        div_q   <= bit_div(speed_i);
        tx_sh_q <= opcode_i;
      end
    end else if (last_ph) begin
      ph_q    <= '0;
      rx_sh_q <= captured;
      if (last_bit) begin
        bit_q <= '0;
        if (last_byte) begin
          run_q <= 1'b0;
        end else begin
          byte_q  <= byte_q + 1'b1;
          tx_sh_q <= (byte_q < BYW'(tx_cnt_i)) ? next_tx : '0;
        end
      end else begin
        bit_q   <= bit_q + 1'b1;
        tx_sh_q <= {tx_sh_q[DW-2:0], 1'b0};
      end
    end else begin
      ph_q <= ph_q + 3'd1;
    end
  end

  assign fifo_wr_o    = run_q && last_ph && last_bit && byte_q != '0;
  assign fifo_wdata_o = captured;
  assign busy_o       = run_q;
  assign cs_no        = !run_q;
  assign mosi_o       = run_q & tx_sh_q[DW-1];
  assign sck_o        = run_q && (ph_q >= div_q - (div_q >> 1));

  AST_SCK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sck_o); // R8
  AST_MOSI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && $past(run_q) && sck_o && $past(sck_o) |-> $stable(mosi_o)); // R8
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o); // R4
  AST_PH_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> ph_q < div_q); // R9
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine import spi_cmd_pkg::*; #(
  parameter int DW    = 8,
  parameter int CW    = 4,
  parameter int DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic              busy_o,
  output logic              spi_sck_o,
  output logic              spi_mosi_o,
  input  logic              spi_miso_i,
  output logic              spi_cs_no
);
  localparam int PW = $clog2(DEPTH);

  logic [DW-1:0] opcode, fifo_cur, fifo_next, eng_wdata;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [1:0]    speed;
  logic [PW-1:0] ptr;
  logic          start, rewind, reg_fwr, reg_fadv, eng_fwr, busy;

  spi_cmd_regs #(.DW(DW), .CW(CW), .PW(PW)) u_regs (
    .clk_i, .rst_ni,
    .addr_i(bus_addr_i), .wr_i(bus_wr_i), .rd_i(bus_rd_i),
    .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
    .busy_i(busy), .ptr_i(ptr), .fifo_cur_i(fifo_cur),
    .opcode_o(opcode), .tx_cnt_o(tx_cnt), .rx_cnt_o(rx_cnt), .speed_o(speed),
    .start_o(start), .rewind_o(rewind), .fifo_wr_o(reg_fwr), .fifo_adv_o(reg_fadv)
  );

  spi_cmd_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk_i, .rst_ni,
    .rewind_i(rewind), .adv_i(reg_fadv | eng_fwr),
    .wr_en_i(reg_fwr | eng_fwr),
    .wr_data_i(eng_fwr ? eng_wdata : bus_wdata_i),
    .cur_o(fifo_cur), .next_o(fifo_next), .ptr_o(ptr)
  );

  spi_cmd_seq #(.DW(DW), .CW(CW)) u_seq (
    .clk_i, .rst_ni,
    .start_i(start), .opcode_i(opcode), .tx_cnt_i(tx_cnt), .rx_cnt_i(rx_cnt),
    .speed_i(speed), .fifo_cur_i(fifo_cur), .fifo_next_i(fifo_next),
    .fifo_wr_o(eng_fwr), .fifo_wdata_o(eng_wdata), .busy_o(busy),
    .sck_o(spi_sck_o), .mosi_o(spi_mosi_o), .miso_i(spi_miso_i), .cs_no(spi_cs_no)
  );

  assign busy_o = busy;

  AST_BUS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !eng_fwr |=> $stable(ptr)); // R10
endmodule

// File: tb/sim_spi_cmd_engine.sv
module sim_spi_cmd_engine;
  import spi_cmd_pkg::*;

  logic clk = 0, rst_n = 0;
  logic [3:0] addr = '0;
  logic wr = 0, rd = 0, miso = 0;
  logic [7:0] wdata = '0, rdata;
  logic busy, sck, mosi, cs_n;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  spi_cmd_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .busy_o(busy), .spi_sck_o(sck),
    .spi_mosi_o(mosi), .spi_miso_i(miso), .spi_cs_no(cs_n)
  );

  // flash model
  logic [7:0] miso_pat [32];
  logic [7:0] mosi_log [32];
  int fall_cnt = 0, rise_cnt = 0;
  always @(negedge cs_n) begin
    fall_cnt = 0; rise_cnt = 0; miso = miso_pat[0][7];
  end
  always @(negedge sck) if (!cs_n) begin
    fall_cnt++;
    miso = miso_pat[fall_cnt/8][7-(fall_cnt%8)];
  end
  always @(posedge sck) begin
    mosi_log[rise_cnt/8][7-(rise_cnt%8)] = mosi;
    rise_cnt++;
  end

  typedef struct packed {
    logic [1:0] speed;
    logic [7:0] opc;
    logic [3:0] tx;
    logic [3:0] rx;
    logic [7:0] seed;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd1, 8'h9F, 4'd0, 4'd3, 8'h10},
    '{2'd2, 8'h03, 4'd3, 4'd4, 8'h20},
    '{2'd3, 8'h05, 4'd0, 4'd1, 8'h30},
    '{2'd0, 8'h06, 4'd0, 4'd0, 8'h40},
    '{2'd1, 8'h0B, 4'd5, 4'd5, 8'h50},
    '{2'd2, 8'h02, 4'd8, 4'd0, 8'h60}
  };

  function automatic logic [7:0] tx_byte(logic [7:0] s, int i);
    return s + 8'(i * 17);
  endfunction
  function automatic logic [7:0] rsp_byte(logic [7:0] s, int j);
    return s ^ 8'(165 + j * 29);
  endfunction
  function automatic int div_exp(logic [1:0] s);
    return (s == 2'd1) ? 2 : (s == 2'd2) ? 3 : 4;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1; #1 d = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic wait_idle(inout int cyc, inout int csl);
    while (busy) begin
      @(negedge clk);
      if (busy) cyc++;
      if (!cs_n) csl++;
    end
  endtask

  task automatic go(input logic [7:0] cmd, output int cyc, output int csl);
    bus_write(A_CTL, cmd);
    cyc = busy ? 1 : 0;
    csl = !cs_n ? 1 : 0;
    wait_idle(cyc, csl);
  endtask

  task automatic run_vec(input vec_t v);
    int n, dv, p, cyc, csl;
    logic [7:0] model [8];
    bit known [8];
    logic [7:0] exp_out [32];
    logic [7:0] d;
    n = 1 + int'(v.tx) + int'(v.rx);
    dv = div_exp(v.speed);
    for (int j = 0; j < 32; j++) miso_pat[j] = rsp_byte(v.seed, j);
    for (int i = 0; i < 8; i++) known[i] = 0;
    bus_write(A_STA, {2'b0, v.speed, 4'b0});
    bus_write(A_OPC, v.opc);
    bus_write(A_CNT, {v.rx, v.tx});
    bus_write(A_CTL, 8'h10);
    for (int i = 0; i < int'(v.tx); i++) begin
      bus_write(A_DAT, tx_byte(v.seed, i));
      model[i%8] = tx_byte(v.seed, i);
      known[i%8] = 1;
    end
    bus_read(A_STA, d);
    chk(int'(d[2:0]) == int'(v.tx) % 8, "R5 load pointer", d[2:0], int'(v.tx) % 8);
    exp_out[0] = v.opc;
    p = 0;
    for (int k = 1; k < n; k++) begin
      exp_out[k] = (k <= int'(v.tx)) ? model[p] : 8'h00;
      model[p] = miso_pat[k];
      known[p] = 1;
      p = (p + 1) % 8;
    end
    go(8'h11, cyc, csl);   // R3 rewind and start together
    chk(cyc == n * 8 * dv, "R9 command length", cyc, n * 8 * dv);
    chk(csl == cyc, "R8 chip select window", csl, cyc);
    for (int k = 0; k < n; k++)
      chk(mosi_log[k] == exp_out[k], (k == 0) ? "R1 opcode out" : "R7 mosi byte",
          mosi_log[k], exp_out[k]);
    bus_read(A_STA, d);
    chk(int'(d[2:0]) == p && d[5:4] == v.speed, "R6 end pointer", d, {v.speed, 1'b0, 3'(p)});
    bus_read(A_CNT, d);
    chk(d == {v.rx, v.tx}, "R2 count readback", d, {v.rx, v.tx});
    bus_write(A_CTL, 8'h10);
    for (int i = 0; i < 8; i++) begin
      bus_read(A_DAT, d);
      if (known[i]) chk(d == model[i], "R6 fifo entry", d, model[i]);
    end
  endtask

  initial begin
    #500_000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int cyc, csl;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // reset state
    chk(busy == 0 && cs_n == 1 && sck == 0, "R4 reset idle", {busy, cs_n, sck}, 3'b010);
    bus_read(A_STA, d);
    chk(d == 8'h30, "R9 reset speed and pointer", d, 8'h30);
    bus_read(A_CTL, d);
    chk(d == 8'h00, "R4 reset control", d, 0);
    bus_read(A_CNT, d);
    chk(d == 8'h00, "R2 reset counts", d, 0);

    foreach (VECS[i]) run_vec(VECS[i]);

    // R3: rewind alone moves pointer, no command
    bus_write(A_DAT, 8'hA1); bus_write(A_DAT, 8'hA2); bus_write(A_DAT, 8'hA3);
    bus_read(A_STA, d);
    chk(d[2:0] == 3'd3, "R5 pointer after writes", d[2:0], 3);
    bus_write(A_CTL, 8'h10);
    chk(busy == 0 && cs_n == 1, "R3 rewind does not start", {busy, cs_n}, 2'b01);
    bus_read(A_STA, d);
    chk(d[2:0] == 3'd0, "R3 rewind pointer", d[2:0], 0);
    bus_read(A_DAT, d);
    chk(d == 8'hA1, "R5 read at pointer", d, 8'hA1);

    // R5: bus wrap
    bus_write(A_CTL, 8'h10);
    for (int i = 0; i < 9; i++) bus_write(A_DAT, 8'hC0 + 8'(i));
    bus_read(A_STA, d);
    chk(d[2:0] == 3'd1, "R5 pointer wrap", d[2:0], 1);
    bus_write(A_CTL, 8'h10);
    bus_read(A_DAT, d);
    chk(d == 8'hC8, "R5 wrapped overwrite", d, 8'hC8);

    // R4 / R10: accesses while busy are dropped
    for (int j = 0; j < 32; j++) miso_pat[j] = rsp_byte(8'h77, j);
    bus_write(A_STA, 8'h30);
    bus_write(A_OPC, 8'h35);
    bus_write(A_CNT, 8'h40);
    bus_write(A_CTL, 8'h10);
    bus_write(A_CTL, 8'h01);
    bus_read(A_CTL, d);
    chk(d == 8'h01, "R4 control reads busy", d, 1);
    chk(busy == 1 && cs_n == 0, "R4 busy and chip select", {busy, cs_n}, 2'b10);
    bus_write(A_OPC, 8'hEE);
    bus_write(A_CNT, 8'hFF);
    bus_write(A_DAT, 8'h99);
    bus_read(A_DAT, d);
    bus_write(A_STA, 8'h10);
    bus_write(A_CTL, 8'h11);
    cyc = 0; csl = 0;
    wait_idle(cyc, csl);
    chk(cs_n == 1 && busy == 0, "R4 release", {cs_n, busy}, 2'b10);
    bus_read(A_CTL, d);
    chk(d == 8'h00, "R4 control self clear", d, 0);
    repeat (200) @(negedge clk);
    chk(busy == 0, "R10 no second start", busy, 0);
    bus_read(A_OPC, d);
    chk(d == 8'h35, "R10 opcode kept", d, 8'h35);
    bus_read(A_CNT, d);
    chk(d == 8'h40, "R10 counts kept", d, 8'h40);
    bus_read(A_STA, d);
    chk(d == 8'h34, "R10 speed and pointer kept", d, 8'h34);
    chk(mosi_log[0] == 8'h35, "R1 opcode out", mosi_log[0], 8'h35);
    bus_write(A_CTL, 8'h10);
    bus_read(A_DAT, d);
    chk(d == rsp_byte(8'h77, 1), "R10 fifo not written by bus", d, rsp_byte(8'h77, 1));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule